// File: doc/BRIEF.md
# GPIO Edge Interrupt Cause Controller

This block watches a 32-pin GPIO bank for signal edges and turns them into interrupt causes. Every pin has its own rising-edge enable and its own falling-edge enable. When an enabled edge is seen, a sticky cause bit for that pin is set. Software clears cause bits by writing ones to a clear address.

A separate per-pin event enable decides which pending causes are reported. The masked cause word (cause AND event enable) can be read back, and a single interrupt line is high while any bit of it is set. Cause bits latch whether or not the event enable is set, so enabling a pin's event later shows an edge that was already captured.

The pin inputs are expected to be synchronized already. An edge is found by comparing the present sample with the sample taken one cycle earlier. Control is through a simple 32-bit register port: a write strobe with address and data, and combinational read data selected by the same address.

Top module: `gpio_edge_cause`

## Requirements
- R1: After reset all enables and all cause bits are 0, irq_o is low and every readable address returns 0.
- R2: With bit n of the rising enable (address 0x44) set, a 0-to-1 change on pin n sets cause bit n on the clock edge that first samples the new pin value.
- R3: With bit n of the falling enable (address 0x48) set, a 1-to-0 change on pin n sets cause bit n on the clock edge that first samples the new pin value.
- R4: With both enables set for a pin, edges in either direction set its cause bit.
- R5: An edge on a pin whose rising and falling enables are both 0 sets no cause bit.
- R6: Reading address 0x80 returns cause AND event enable (event enable at address 0x94). Cause bits latch even while the event enable bit is 0.
- R7: irq_o is high exactly when the masked cause word is nonzero, and several pins may be pending at the same time.
- R8: Writing to address 0x98 clears the cause bits whose data bits are 1 and leaves the other cause bits unchanged.
- R9: When an enabled edge and a clear of the same bit happen on the same clock edge, the cause bit ends up set.
- R10: Addresses 0x44, 0x48 and 0x94 read back the last value written. Any other address, including 0x98, reads 0. Writes to 0x80 or to any unmapped address change no state.
- R11: A pin held at a constant level does not set its cause bit again after that bit has been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address for reads and writes |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| pin_i | input | 32 | Synchronized pin levels |
| irq_o | output | 1 | Interrupt, high while any enabled cause is pending |

## Verification
Single-pin rising and falling transitions are driven with one direction enabled at a time. This tells a correct direction decode apart from one that swaps the two enables or ignores one of them. Pins with both enables set and pins with neither set are toggled to check the combined case and the disabled case. Multi-pin patterns with partial event enables and partial clear masks show whether masking and clearing act per bit and not on the whole word. A clear issued on the same edge as a new edge, and a pin that stays high after its cause was cleared, separate set-wins priority and true edge detection from level sensing.

// File: rtl/gec_pkg.sv
package gec_pkg;
  localparam int unsigned NPINS  = 32;
  localparam int unsigned ADDR_W = 8;
  localparam logic [ADDR_W-1:0] ADDR_RISE_EN = 8'h44;
  localparam logic [ADDR_W-1:0] ADDR_FALL_EN = 8'h48;
  localparam logic [ADDR_W-1:0] ADDR_MASKED  = 8'h80;
  localparam logic [ADDR_W-1:0] ADDR_EVT_EN  = 8'h94;
  localparam logic [ADDR_W-1:0] ADDR_CLEAR   = 8'h98;
endpackage

// File: rtl/gec_edge_detect.sv
module gec_edge_detect #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] rise_o,
  output logic [NPINS-1:0] fall_o
);
  logic [NPINS-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= pin_i;
  end

  assign rise_o = pin_i & ~prev_q;
  assign fall_o = ~pin_i & prev_q;

  // R2
  rise_follows_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((rise_o & $past(pin_i)) == '0));
endmodule

// File: rtl/gec_cause_reg.sv
module gec_cause_reg #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] set_i,
  input  logic [NPINS-1:0] clr_i,
  output logic [NPINS-1:0] cause_o
);
  logic [NPINS-1:0] cause_q;

  for (genvar i = 0; i < NPINS; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cause_q[i] <= 1'b0;
      else if (set_i[i]) cause_q[i] <= 1'b1;  // set wins over clear
      else if (clr_i[i]) cause_q[i] <= 1'b0;
    end
  end

  assign cause_o = cause_q;

  // R9
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((cause_o & $past(set_i)) == $past(set_i)));
  // R8
  clear_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0) |=> ((cause_o & $past(clr_i & ~set_i)) == '0));
  // R5
  no_spurious_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((cause_o & ~$past(cause_o) & ~$past(set_i)) == '0));
endmodule

// File: rtl/gec_regfile.sv
module gec_regfile
  import gec_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPINS-1:0]  wdata_i,
  input  logic [NPINS-1:0]  masked_i,
  output logic [NPINS-1:0]  rdata_o,
  output logic [NPINS-1:0]  rise_en_o,
  output logic [NPINS-1:0]  fall_en_o,
  output logic [NPINS-1:0]  evt_en_o,
  output logic [NPINS-1:0]  clr_o
);
  logic [NPINS-1:0] rise_en_q, fall_en_q, evt_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_en_q <= '0;
      fall_en_q <= '0;
      evt_en_q  <= '0;
    end else if (we_i) begin
      if (addr_i == ADDR_RISE_EN) rise_en_q <= wdata_i;
      if (addr_i == ADDR_FALL_EN) fall_en_q <= wdata_i;
      if (addr_i == ADDR_EVT_EN)  evt_en_q  <= wdata_i;
    end
  end

  assign clr_o = (we_i && addr_i == ADDR_CLEAR) ? wdata_i : '0;

  always_comb begin
    unique case (addr_i)
      ADDR_RISE_EN: rdata_o = rise_en_q;
      ADDR_FALL_EN: rdata_o = fall_en_q;
      ADDR_EVT_EN:  rdata_o = evt_en_q;
      ADDR_MASKED:  rdata_o = masked_i;
      default:      rdata_o = '0;
    endcase
  end

  assign rise_en_o = rise_en_q;
  assign fall_en_o = fall_en_q;
  assign evt_en_o  = evt_en_q;

  // R10
  enables_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(rise_en_q) && $stable(fall_en_q) && $stable(evt_en_q)));
endmodule

// File: rtl/gpio_edge_cause.sv
module gpio_edge_cause
  import gec_pkg::*;
#(
  parameter int unsigned NPINS = gec_pkg::NPINS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [NPINS-1:0]  reg_wdata_i,
  output logic [NPINS-1:0]  reg_rdata_o,
  input  logic [NPINS-1:0]  pin_i,
  output logic              irq_o
);
  logic [NPINS-1:0] rise, fall, rise_en, fall_en, evt_en, clr, cause, masked, set;

  gec_edge_detect #(.NPINS(NPINS)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i), .rise_o(rise), .fall_o(fall)
  );

  assign set = (rise & rise_en) | (fall & fall_en);

  gec_cause_reg #(.NPINS(NPINS)) u_cause (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set), .clr_i(clr), .cause_o(cause)
  );

  assign masked = cause & evt_en;
  assign irq_o  = |masked;

  gec_regfile #(.NPINS(NPINS)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .masked_i(masked), .rdata_o(reg_rdata_o),
    .rise_en_o(rise_en), .fall_en_o(fall_en), .evt_en_o(evt_en), .clr_o(clr)
  );

  // R7
  irq_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((evt_en != '0) && (cause != '0)));
endmodule

// File: tb/gpio_edge_cause_tb_top.sv
`timescale 1ns/1ps
module gpio_edge_cause_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pins = '0;
  logic        irq;
  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;  // 50 MHz

  gpio_edge_cause dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .pin_i(pins), .irq_o(irq)
  );

  localparam logic [7:0] A_RISE = 8'h44, A_FALL = 8'h48, A_MASK = 8'h80,
                         A_EVT = 8'h94, A_CLR = 8'h98;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic drive_pins(input logic [31:0] v);
    pins = v;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pins = '0; we = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    check("R1 irq", {31'b0, irq}, 32'h0);
    rd(A_RISE, d); check("R1 rise_en", d, 32'h0);
    rd(A_FALL, d); check("R1 fall_en", d, 32'h0);
    rd(A_EVT, d);  check("R1 evt_en", d, 32'h0);
    wr(A_EVT, 32'hFFFF_FFFF);
    rd(A_MASK, d); check("R1 cause", d, 32'h0);
  endtask

  task automatic t_rise_fall();
    logic [31:0] d;
    do_reset();
    wr(A_EVT, 32'hFFFF_FFFF);
    wr(A_RISE, 32'h0000_0001);
    wr(A_FALL, 32'h0000_0002);
    drive_pins(32'h0000_0002);           // pin1 rises: only fall enabled there
    rd(A_MASK, d); check("R2 rise on fall-only pin", d, 32'h0);
    drive_pins(32'h0000_0001);           // pin0 rises, pin1 falls
    rd(A_MASK, d); check("R2/R3 both directions", d, 32'h3);
    wr(A_CLR, 32'h3);
    drive_pins(32'h0000_0002);           // pin0 falls (rise-only), pin1 rises (fall-only)
    rd(A_MASK, d); check("R3 wrong directions ignored", d, 32'h0);
  endtask

  task automatic t_both_none();
    logic [31:0] d;
    do_reset();
    wr(A_EVT, 32'hFFFF_FFFF);
    wr(A_RISE, 32'h0000_0010);
    wr(A_FALL, 32'h0000_0010);
    drive_pins(32'h0000_0030);           // pin4 rises, pin5 rises (no enables)
    rd(A_MASK, d); check("R4 both rise", d, 32'h10);
    check("R5 disabled pin", d & 32'h20, 32'h0);
    wr(A_CLR, 32'h10);
    drive_pins(32'h0000_0000);
    rd(A_MASK, d); check("R4 both fall", d, 32'h10);
  endtask

  task automatic t_mask_irq();
    logic [31:0] d;
    do_reset();
    wr(A_RISE, 32'h8000_0101);
    drive_pins(32'h8000_0101);
    rd(A_MASK, d); check("R6 masked with evt off", d, 32'h0);
    check("R7 irq low while masked", {31'b0, irq}, 32'h0);
    wr(A_EVT, 32'h8000_0001);
    rd(A_MASK, d); check("R6 latched despite mask", d, 32'h8000_0001);
    check("R7 irq high", {31'b0, irq}, 32'h1);
    wr(A_CLR, 32'h0000_0001);
    check("R7 irq still high, other pending", {31'b0, irq}, 32'h1);
    rd(A_MASK, d); check("R8 partial clear", d, 32'h8000_0000);
    wr(A_EVT, 32'h0000_0100);
    rd(A_MASK, d); check("R8 untouched bit kept", d, 32'h0000_0100);
    wr(A_CLR, 32'h0000_0100);
    check("R7 irq low after clear", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_set_vs_clear();
    logic [31:0] d;
    do_reset();
    wr(A_EVT, 32'hFFFF_FFFF);
    wr(A_RISE, 32'h0000_0040);
    wr(A_FALL, 32'h0000_0040);
    drive_pins(32'h0000_0040);
    rd(A_MASK, d); check("R9 precondition", d, 32'h40);
    pins = 32'h0;                        // falling edge on same edge as clear
    wr(A_CLR, 32'h0000_0040);
    rd(A_MASK, d); check("R9 set beats clear", d, 32'h40);
    wr(A_CLR, 32'h0000_0040);
    rd(A_MASK, d); check("R8 clear alone", d, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    do_reset();
    wr(A_EVT, 32'hFFFF_FFFF);
    wr(A_RISE, 32'h0000_0008);
    drive_pins(32'h0000_0008);
    wr(A_CLR, 32'h0000_0008);
    repeat (3) @(negedge clk);
    rd(A_MASK, d); check("R11 steady level no retrigger", d, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    do_reset();
    wr(A_RISE, 32'hA5A5_0F0F);
    wr(A_FALL, 32'h1234_5678);
    wr(A_EVT, 32'hDEAD_BEEF);
    wr(A_MASK, 32'hFFFF_FFFF);
    wr(8'h20, 32'hFFFF_FFFF);
    rd(A_RISE, d); check("R10 rise readback", d, 32'hA5A5_0F0F);
    rd(A_FALL, d); check("R10 fall readback", d, 32'h1234_5678);
    rd(A_EVT, d);  check("R10 evt readback", d, 32'hDEAD_BEEF);
    rd(A_MASK, d); check("R10 masked write ignored", d, 32'h0);
    rd(A_CLR, d);  check("R10 clear reads zero", d, 32'h0);
    rd(8'h20, d);  check("R10 unmapped reads zero", d, 32'h0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_rise_fall();
        t_both_none();
        t_mask_irq();
        t_set_vs_clear();
        t_level();
        t_regs();
      end
      begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule